// File: doc/BRIEF.md
# DSP Upper Half-Word Logical Shifter with Status Flags

This block is the logical-shift stage of a DSP datapath, together with the status flags that a shift updates. A 32-bit source is shifted by a signed amount taken from a field of the second operand. Only the upper half-word moves: a positive amount shifts it toward bit 31, and a negative amount shifts it toward bit 16. Vacated positions fill with zeros, and the lower half-word of the result is always zero.

The shifted result is combinational. A five-bit status register (dc, n, z, v, gt) is loaded on the clock edge when an unconditional shift is issued. A 3-bit select code chooses what the dc flag means: the last bit shifted out, the sign, zero, or overflow. A conditional shift leaves every status bit untouched.

Top module: `dsp_lshift`

## Requirements
- R1: The shift amount is bits 22..16 of `amt_i`, read as 7-bit two's complement. Values above +16 act as +16, and values below -16 act as -16.
- R2: For a positive amount k, result bits 31..16 are `src_i[31:16]` shifted left by k. For a negative amount -m, they are `src_i[31:16]` shifted right by m. Zeros fill in from both sides, and result bits 15..0 are always 0.
- R3: With an amount of 0, result bits 31..16 equal `src_i[31:16]`.
- R4: The status register is loaded on a rising clock edge only when `valid_i`=1 and `cond_i`=0. It keeps its value when `valid_i`=0.
- R5: When `valid_i`=1 and `cond_i`=1, no status bit changes.
- R6: On a load, n takes result bit 31, z is 1 exactly when the full 32-bit result is zero, and v and gt are cleared.
- R7: With `sel_i`=000, a load sets dc to the last bit shifted out of the half-word. For a left shift by k this is source bit 32-k. For a right shift by m it is source bit 15+m. For an amount of 0, dc is 0.
- R8: With `sel_i`=001, a load sets dc equal to the new n.
- R9: With `sel_i`=010, a load sets dc equal to the new z.
- R10: With `sel_i`=011, a load clears dc.
- R11: With `sel_i` from 100 to 111, a load keeps dc at its previous value. The other flags still update.
- R12: While `rst_ni` is low, all five status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Source operand |
| amt_i | input | 32 | Second operand; bits 22..16 hold the signed shift amount |
| sel_i | input | 3 | dc meaning select |
| valid_i | input | 1 | Shift issued this cycle |
| cond_i | input | 1 | 1 = conditional instruction (flags untouched) |
| res_o | output | 32 | Shifted result (combinational) |
| dc_o | output | 1 | Selectable condition flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| gt_o | output | 1 | Greater-than flag |

## Verification
An error in amount decoding or saturation appears on `res_o` in the same cycle. A wrong fill bit or a stray lower-half bit appears the same way. A wrong flag load, or a missed load suppression, appears on the flag outputs one clock edge after the offending instruction. Once a wrong value is stored, it persists until the next unconditional shift, so every following idle or conditional cycle shows the same stale error. The carry-mode dc is the only path that exposes the shifted-out bit. The bench therefore pushes every amount from -16 to +16, plus out-of-range fields, through select code 000.

// File: rtl/dsp_lshift_pkg.sv
package dsp_lshift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;

  typedef enum logic [2:0] {
    DC_CARRY = 3'b000,
    DC_NEG   = 3'b001,
    DC_ZERO  = 3'b010,
    DC_OVF   = 3'b011
  } dc_sel_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } flags_t;
endpackage

// File: rtl/dsp_lshift_amt.sv
module dsp_lshift_amt #(
  parameter int unsigned OPND_W  = 32,
  parameter int unsigned FIELD_LSB = 16,
  parameter int unsigned FIELD_W = 7,
  parameter int unsigned MAX_SH  = 16,
  localparam int unsigned MAG_W  = $clog2(MAX_SH + 1)
) (
  input  logic [OPND_W-1:0] opnd_i,
  output logic              right_o,
  output logic [MAG_W-1:0]  mag_o
);
  logic signed [FIELD_W-1:0] fld;
  logic signed [FIELD_W:0]   ext;
  logic signed [FIELD_W:0]   lim_pos;
  logic signed [FIELD_W:0]   lim_neg;
  logic        [FIELD_W:0]   neg_val;

  assign fld     = opnd_i[FIELD_LSB +: FIELD_W];
  assign ext     = {fld[FIELD_W-1], fld};
  assign lim_pos = (FIELD_W+1)'(MAX_SH);
  assign lim_neg = -lim_pos;
  assign neg_val = -ext;

  // saturate to +/-MAX_SH
  always_comb begin
    if (ext > lim_pos) begin
      right_o = 1'b0;
      mag_o   = MAG_W'(MAX_SH);
    end else if (ext < lim_neg) begin
      right_o = 1'b1;
      mag_o   = MAG_W'(MAX_SH);
    end else if (ext < 0) begin
      right_o = 1'b1;
      mag_o   = neg_val[MAG_W-1:0];
    end else begin
      right_o = 1'b0;
      mag_o   = ext[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/dsp_lshift_core.sv
module dsp_lshift_core #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned MAG_W = $clog2(HALF_W + 1),
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic              right_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic [FULL_W-1:0] res_o,
  output logic              out_bit_o
);
  logic [FULL_W-1:0] lw;
  logic [FULL_W-1:0] rw;

  // the bit that crosses the half-word boundary last lands at HALF_W / HALF_W-1
  assign lw = {{HALF_W{1'b0}}, half_i} << mag_i;
  assign rw = {half_i, {HALF_W{1'b0}}} >> mag_i;

  always_comb begin
    if (right_i) begin
      res_o     = {rw[FULL_W-1:HALF_W], {HALF_W{1'b0}}};
      out_bit_o = rw[HALF_W-1];
    end else begin
      res_o     = {lw[HALF_W-1:0], {HALF_W{1'b0}}};
      out_bit_o = lw[HALF_W];
    end
  end
endmodule

// File: rtl/dsp_lshift_flags.sv
module dsp_lshift_flags
  import dsp_lshift_pkg::*;
#(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             cond_i,
  input  logic [2:0]       sel_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             out_bit_i,
  output flags_t           flags_o
);
  flags_t nxt;
  logic   res_zero;

  assign res_zero = (res_i == '0);

  always_comb begin
    nxt    = flags_o;
    nxt.n  = res_i[RES_W-1];
    nxt.z  = res_zero;
    nxt.v  = 1'b0;
    nxt.gt = 1'b0;
    case (sel_i)
      DC_CARRY: nxt.dc = out_bit_i;
      DC_NEG:   nxt.dc = res_i[RES_W-1];
      DC_ZERO:  nxt.dc = res_zero;
      DC_OVF:   nxt.dc = 1'b0;
      default:  nxt.dc = flags_o.dc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flags_o <= '0;
    else if (upd_i && !cond_i)  flags_o <= nxt;
  end

  // R5
  cond_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && cond_i) |=> $stable(flags_o));
  // R4
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));
  // R6
  v_gt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cond_i) |=> (!flags_o.v && !flags_o.gt));
  // R8
  dc_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cond_i && sel_i == DC_NEG) |=> (flags_o.dc == flags_o.n));
  // R9
  dc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cond_i && sel_i == DC_ZERO) |=> (flags_o.dc == flags_o.z));
  // R10
  dc_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cond_i && sel_i == DC_OVF) |=> !flags_o.dc);
  // R11
  dc_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !cond_i && sel_i[2]) |=> $stable(flags_o.dc));
endmodule

// File: rtl/dsp_lshift.sv
module dsp_lshift
  import dsp_lshift_pkg::*;
#(
  parameter int unsigned AMT_LSB = 16,
  parameter int unsigned AMT_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] amt_i,
  input  logic [2:0]        sel_i,
  input  logic              valid_i,
  input  logic              cond_i,
  output logic [DATA_W-1:0] res_o,
  output logic              dc_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              gt_o
);
  localparam int unsigned MAG_W = $clog2(HALF_W + 1);

  logic             right;
  logic [MAG_W-1:0] mag;
  logic             out_bit;
  flags_t           flags;

  dsp_lshift_amt #(
    .OPND_W(DATA_W), .FIELD_LSB(AMT_LSB), .FIELD_W(AMT_W), .MAX_SH(HALF_W)
  ) u_amt (
    .opnd_i (amt_i),
    .right_o(right),
    .mag_o  (mag)
  );

  dsp_lshift_core #(.HALF_W(HALF_W)) u_core (
    .half_i   (src_i[DATA_W-1:HALF_W]),
    .right_i  (right),
    .mag_i    (mag),
    .res_o    (res_o),
    .out_bit_o(out_bit)
  );

  dsp_lshift_flags #(.RES_W(DATA_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (valid_i),
    .cond_i   (cond_i),
    .sel_i    (sel_i),
    .res_i    (res_o),
    .out_bit_i(out_bit),
    .flags_o  (flags)
  );

  assign dc_o = flags.dc;
  assign n_o  = flags.n;
  assign z_o  = flags.z;
  assign v_o  = flags.v;
  assign gt_o = flags.gt;

  // R2
  low_half_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[HALF_W-1:0] == '0);
  // R3
  zero_amt_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amt_i[AMT_LSB +: AMT_W] == '0) |-> (res_o[DATA_W-1:HALF_W] == src_i[DATA_W-1:HALF_W]));
endmodule

// File: tb/dsp_lshift_bench.sv
module dsp_lshift_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0, amt = '0;
  logic [2:0]  sel = '0;
  logic        valid = 1'b0, cond = 1'b0;
  logic [31:0] res;
  logic        dc, n, z, v, gt;

  int checks = 0, fails = 0;
  logic [4:0] mflags = '0;  // {dc,n,z,v,gt}

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_lshift u_dsp_lshift (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .amt_i(amt), .sel_i(sel),
    .valid_i(valid), .cond_i(cond), .res_o(res),
    .dc_o(dc), .n_o(n), .z_o(z), .v_o(v), .gt_o(gt)
  );

  function automatic int amt_of(logic [31:0] a);
    int k;
    k = $signed(a[22:16]);
    if (k > 16) k = 16;
    if (k < -16) k = -16;
    return k;
  endfunction

  function automatic logic [31:0] exp_res(logic [31:0] s, logic [31:0] a);
    int k;
    logic [31:0] r;
    k = amt_of(a);
    r = '0;
    for (int i = 0; i < 16; i++) begin
      int j;
      j = i - k;  // destination bit i of the half takes source half bit j
      if (j >= 0 && j < 16) r[16+i] = s[16+j];
    end
    return r;
  endfunction

  function automatic logic exp_out(logic [31:0] s, logic [31:0] a);
    int k;
    k = amt_of(a);
    if (k > 0) return s[32-k];
    if (k < 0) return s[15-k];
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [31:0] s, logic [31:0] a, logic [2:0] sl,
                      logic vl, logic cd, string req);
    logic [31:0] er;
    logic [4:0]  nf;
    @(negedge clk);
    src = s; amt = a; sel = sl; valid = vl; cond = cd;
    #1;
    er = exp_res(s, a);
    chk({req, " res"}, res, er);
    nf = mflags;
    if (vl && !cd) begin
      nf[3] = er[31];
      nf[2] = (er == 0);
      nf[1] = 1'b0;
      nf[0] = 1'b0;
      case (sl)
        3'b000: nf[4] = exp_out(s, a);
        3'b001: nf[4] = er[31];
        3'b010: nf[4] = (er == 0);
        3'b011: nf[4] = 1'b0;
        default: nf[4] = mflags[4];
      endcase
    end
    @(posedge clk);
    mflags = nf;
    @(negedge clk);
    chk({req, " flags"}, {27'b0, dc, n, z, v, gt}, {27'b0, mflags});
    valid = 1'b0;
  endtask

  function automatic logic [31:0] amt_word(int k);
    logic [6:0] f;
    f = 7'(k);
    return {$urandom, f, 16'h0} & 32'hFFFF_FFFF;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #(CLK_PERIOD * 2);
    // R12 reset state
    chk("R12", {27'b0, dc, n, z, v, gt}, 32'h0);
    rst_n = 1'b1;

    // R2 R7 every in-range amount through carry mode
    for (int k = -16; k <= 16; k++) begin
      step(32'hB5A3_1234, amt_word(k), 3'b000, 1'b1, 1'b0, "R7");
      step(32'h6C39_FFFF, amt_word(k), 3'b000, 1'b1, 1'b0, "R2");
    end
    // R3 zero amount pass-through, carry 0
    step(32'hFFFF_FFFF, 32'h0000_0000, 3'b000, 1'b1, 1'b0, "R3");
    // R1 saturation both ends
    step(32'h8001_0000, {9'h0, 7'd63, 16'h0}, 3'b000, 1'b1, 1'b0, "R1");
    step(32'h8001_0000, {9'h0, 7'h40, 16'h0}, 3'b000, 1'b1, 1'b0, "R1");
    step(32'h8001_0000, {9'h0, 7'd17, 16'h0}, 3'b000, 1'b1, 1'b0, "R1");
    // R8 R9 R10 modes
    step(32'h4000_0000, amt_word(1), 3'b001, 1'b1, 1'b0, "R8");
    step(32'h0001_0000, amt_word(-1), 3'b010, 1'b1, 1'b0, "R9");
    step(32'hFFFF_0000, amt_word(-1), 3'b011, 1'b1, 1'b0, "R10");
    // R11 reserved keeps dc: set dc=1, then reserved with zero result
    step(32'h8000_0000, amt_word(1), 3'b000, 1'b1, 1'b0, "R11");
    step(32'h0000_0000, amt_word(0), 3'b101, 1'b1, 1'b0, "R11");
    // R5 conditional untouched, R4 idle untouched
    step(32'h0000_0000, amt_word(0), 3'b010, 1'b1, 1'b1, "R5");
    step(32'h0000_0000, amt_word(0), 3'b000, 1'b0, 1'b0, "R4");
    // R6 flags from result
    step(32'h0000_0001, amt_word(3), 3'b001, 1'b1, 1'b0, "R6");

    // random mix
    for (int i = 0; i < 400; i++) begin
      step($urandom, $urandom, 3'($urandom), ($urandom % 4) != 0,
           ($urandom % 3) == 0, "R6");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule